// File: doc/BRIEF.md
# Four-Mode Reloadable Down-Counter Timer

This block is a peripheral timer made of two cascaded reloadable down-counters: a prescaler and a main timer. Each counter has its own 8-bit reload latch, and the latches are written over a simple write-only register bus. The prescaler counts a source pulse. Each prescaler underflow advances the main timer. Each main-timer underflow reloads that counter from its latch and raises a one-cycle interrupt request.

A two-bit mode field picks what the prescaler counts:
- internal ticks (plain timer);
- internal ticks, with an output pin toggled on every underflow (pulse output);
- edges of an external input pin (event counter);
- internal ticks, gated by the level of the input pin (pulse-width measurement).

The internal tick is the system clock divided by 16 or by 2. A single edge-select bit takes on a different meaning in each mode. It sets the starting level of the output pin, the counted input edge, the measured input level, and the edge that raises a separate pin interrupt. A stop bit freezes both counters. While the timer is stopped, a write to a latch also loads the matching counter, so that counting begins from the new value.

Top module: `quad_mode_timer`

## Requirements
- R1: After reset the count output reads 0xFF, both interrupt outputs are low, the output pin is high, and the timer is stopped. Register map: address 0 is the prescaler latch and address 1 is the timer latch. Address 2 is control, with bits [1:0] mode, bit 2 edge-select, bit 3 stop (1 = frozen) and bit 4 source (1 = clock/2, 0 = clock/16).
- R2: With prescaler latch P and timer latch T, mode 00 raises `tmr_irq` once every D·(P+1)·(T+1) clock cycles, where D is 2 when the source bit is 1 and 16 when it is 0.
- R3: On each main-timer underflow the counter is reloaded with the timer latch value, and `tmr_irq` is high for exactly one cycle.
- R4: The mode field uses 01 for pulse output. A control write sets `cntr_out` to its start level: high when edge-select is 0 and low when it is 1. In pulse output mode `cntr_out` then toggles on every timer underflow, in the same cycle that `tmr_irq` rises.
- R5: The mode field uses 10 for event counting. The prescaler counts rising edges of `cntr_in` when edge-select is 0 and falling edges when it is 1; the other edge has no effect. An edge is counted at the third clock edge after the input changes.
- R6: The mode field uses 11 for pulse-width measurement. Internal ticks are counted only while the synchronised `cntr_in` is high (edge-select 0) or low (edge-select 1); at the other level the count holds.
- R7: While the stop bit is 1, the counters do not change except through a latch write.
- R8: A latch write while stopped loads the counter directly. A latch write while running changes only the reload value.
- R9: `pin_irq` pulses for one cycle on a falling edge of `cntr_in` when edge-select is 0 and on a rising edge when it is 1; the other edge raises nothing.
- R10: If a timer underflow falls in the same cycle as a control write that sets the stop bit, `tmr_irq` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cntr_in | input | 1 | External event / gate input (asynchronous) |
| cntr_out | output | 1 | Pulse output pin |
| tmr_irq | output | 1 | One-cycle timer underflow request |
| pin_irq | output | 1 | One-cycle input edge request |
| count_val | output | 8 | Current main-timer count |

## Verification
Register writes take effect at the clock edge that accepts them, and `tmr_irq` and `cntr_out` change at the edge of the underflow that causes them. An input pin change reaches the counters and `pin_irq` at the third clock edge after it, once it has passed the two synchroniser flops. The bench drives inputs on falling edges and waits at least four falling edges after each pin change before it samples. It measures interrupt and toggle periods as counts of falling edges between events, so the unknown phase of the tick divider does not affect the result. The same-cycle stop case is timed by placing the stop write on the exact edge where the event underflow is due.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

   typedef enum logic [1:0] {
      MODE_TIMER = 2'b00,
      MODE_PULSE = 2'b01,
      MODE_EVENT = 2'b10,
      MODE_WIDTH = 2'b11
   } qmt_mode_e;

   typedef struct packed {
      logic      src_fast;
      logic      stop;
      logic      edge_sel;
      qmt_mode_e mode;
   } qmt_ctl_t;

   localparam int CTL_W = $bits(qmt_ctl_t);

   localparam logic [1:0] ADDR_PRE = 2'd0;
   localparam logic [1:0] ADDR_TIM = 2'd1;
   localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/qmt_sync_edge.sv
module qmt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sh;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("qmt_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], din};
         prev <= sh[STAGES-1];
      end
   end

   assign level = sh[STAGES-1];
   assign rise  = sh[STAGES-1] & ~prev;
   assign fall  = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/qmt_tick_gen.sv
module qmt_tick_gen #(
   parameter int DIV_SLOW = 16,
   parameter int DIV_FAST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast,
   output logic tick
);
   localparam int SW = $clog2(DIV_SLOW);
   localparam int FW = $clog2(DIV_FAST);

   generate
      if (DIV_FAST < 2 || DIV_FAST >= DIV_SLOW ||
          (DIV_SLOW & (DIV_SLOW - 1)) != 0 || (DIV_FAST & (DIV_FAST - 1)) != 0) begin : g_bad
         $error("qmt_tick_gen: dividers must be powers of two with 2 <= DIV_FAST < DIV_SLOW");
      end
   endgenerate

   logic [SW-1:0] div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div <= '0;
      else        div <= div + 1'b1;
   end

   assign tick = fast ? (&div[FW-1:0]) : (&div);
endmodule

// File: rtl/qmt_downcnt.sv
module qmt_downcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic         uf
);
   assign uf = en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '1;
      else if (load) cnt <= load_val;
      else if (en)   cnt <= uf ? reload_val : cnt - 1'b1;
   end
endmodule

// File: rtl/quad_mode_timer.sv
module quad_mode_timer
   import qmt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int DIV_SLOW    = 16,
   parameter int DIV_FAST    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cntr_in,
   output logic             cntr_out,
   output logic             tmr_irq,
   output logic             pin_irq,
   output logic [CNT_W-1:0] count_val
);
   generate
      if (CNT_W < CTL_W) begin : g_bad
         $error("quad_mode_timer: CNT_W must hold the control word");
      end
   endgenerate

   logic [CNT_W-1:0] pre_latch, tim_latch, pre_cnt;
   qmt_ctl_t         ctl_q, ctl_new;
   logic             out_q;
   logic             stopped;
   logic             wr_pre, wr_tim, wr_ctl;
   logic             lvl, rise, fall, tick;
   logic             src_pulse, pre_en, pre_uf, tim_uf;

   assign ctl_new = qmt_ctl_t'(wr_data[CTL_W-1:0]);
   assign stopped = ctl_q.stop;
   assign wr_pre  = wr_en && (wr_addr == ADDR_PRE);
   assign wr_tim  = wr_en && (wr_addr == ADDR_TIM);
   assign wr_ctl  = wr_en && (wr_addr == ADDR_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_latch <= '1;
         tim_latch <= '1;
         ctl_q     <= '{src_fast: 1'b0, stop: 1'b1, edge_sel: 1'b0, mode: MODE_TIMER};
      end else begin
         if (wr_pre) pre_latch <= wr_data;
         if (wr_tim) tim_latch <= wr_data;
         if (wr_ctl) ctl_q     <= ctl_new;
      end
   end

   qmt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cntr_in),
      .level(lvl), .rise(rise), .fall(fall)
   );

   qmt_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
      .clk(clk), .rst_n(rst_n), .fast(ctl_q.src_fast), .tick(tick)
   );

   always_comb begin
      unique case (ctl_q.mode)
         MODE_EVENT: src_pulse = ctl_q.edge_sel ? fall : rise;
         MODE_WIDTH: src_pulse = tick && (lvl != ctl_q.edge_sel);
         default:    src_pulse = tick;
      endcase
   end

   assign pre_en = !stopped && src_pulse;

   qmt_downcnt #(.W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(pre_en),
      .load(wr_pre && stopped), .load_val(wr_data), .reload_val(pre_latch),
      .cnt(pre_cnt), .uf(pre_uf)
   );

   qmt_downcnt #(.W(CNT_W)) u_tim (
      .clk(clk), .rst_n(rst_n), .en(pre_uf),
      .load(wr_tim && stopped), .load_val(wr_data), .reload_val(tim_latch),
      .cnt(count_val), .uf(tim_uf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= 1'b1;
         tmr_irq <= 1'b0;
         pin_irq <= 1'b0;
      end else begin
         tmr_irq <= tim_uf;
         pin_irq <= ctl_q.edge_sel ? rise : fall;
         if (wr_ctl)
            out_q <= ~ctl_new.edge_sel;
         else if (ctl_q.mode == MODE_PULSE && tim_uf)
            out_q <= ~out_q;
      end
   end

   assign cntr_out = out_q;
endmodule

// File: rtl/qmt_checker.sv
module qmt_checker
   import qmt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] count_val,
   input logic [CNT_W-1:0] tim_latch,
   input logic             stopped,
   input logic             tmr_irq,
   input logic             pin_irq,
   input logic             cntr_out
);
   logic ctl_wr, tim_wr;
   assign ctl_wr = wr_en && (wr_addr == ADDR_CTL);
   assign tim_wr = wr_en && (wr_addr == ADDR_TIM);

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq |-> (count_val == $past(tim_latch)));

   assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq |=> !tmr_irq);

   assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !tim_wr) |=> (count_val == $past(count_val)));

   assert_out_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cntr_out != $past(cntr_out)) |-> (tmr_irq || $past(ctl_wr)));

   assert_pin_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_irq |=> !pin_irq);
endmodule

bind quad_mode_timer qmt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .count_val(count_val), .tim_latch(tim_latch), .stopped(stopped),
   .tmr_irq(tmr_irq), .pin_irq(pin_irq), .cntr_out(cntr_out)
);

// File: tb/quad_mode_timer_tb.sv
module quad_mode_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       cntr_in = 1'b0;
   logic       cntr_out, tmr_irq, pin_irq;
   logic [7:0] count_val;

   int checks = 0;
   int fails = 0;
   int irq_seen = 0;
   int pin_seen = 0;

   always #10 clk = ~clk;

   quad_mode_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cntr_in(cntr_in), .cntr_out(cntr_out), .tmr_irq(tmr_irq), .pin_irq(pin_irq),
      .count_val(count_val)
   );

   always @(negedge clk) begin
      if (tmr_irq) irq_seen++;
      if (pin_irq) pin_seen++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(input int mode, input int edge_sel, input int stop, input int fast);
      return {3'b000, fast[0], stop[0], edge_sel[0], mode[1:0]};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pin(input logic v);
      @(negedge clk);
      cntr_in = v;
      idle(4);
   endtask

   task automatic irq_period(output int n);
      n = 0;
      while (!tmr_irq) @(negedge clk);
      @(negedge clk);
      n = 1;
      while (!tmr_irq) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      chk(count_val == 8'hFF, "R1 count", count_val, 255);
      chk(!tmr_irq && !pin_irq, "R1 irqs", {tmr_irq, pin_irq}, 0);
      chk(cntr_out == 1'b1, "R1 out", cntr_out, 1);
      idle(40);
      chk(count_val == 8'hFF, "R1 stopped", count_val, 255);
   endtask

   task automatic t_period(input int p, input int t, input int fast);
      int n;
      wr(2, ctl(0, 0, 1, fast));
      wr(0, p[7:0]);
      wr(1, t[7:0]);
      wr(2, ctl(0, 0, 0, fast));
      irq_period(n);
      chk(n == (fast ? 2 : 16) * (p + 1) * (t + 1), "R2 period", n, (fast ? 2 : 16) * (p + 1) * (t + 1));
      chk(count_val == t[7:0], "R3 reload", count_val, t);
   endtask

   task automatic t_pulse();
      int n;
      logic last;
      wr(2, ctl(1, 0, 1, 1));
      chk(cntr_out == 1'b1, "R4 start edge0", cntr_out, 1);
      wr(2, ctl(1, 1, 1, 1));
      chk(cntr_out == 1'b0, "R4 start edge1", cntr_out, 0);
      wr(0, 8'd0);
      wr(1, 8'd3);
      wr(2, ctl(1, 1, 0, 1));
      last = cntr_out;
      while (cntr_out == last) @(negedge clk);
      chk(tmr_irq == 1'b1, "R4 toggle with irq", tmr_irq, 1);
      last = cntr_out;
      n = 0;
      while (cntr_out == last && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(n == 8, "R4 toggle period", n, 8);
   endtask

   task automatic t_stop_load();
      logic [7:0] v;
      wr(2, ctl(0, 0, 1, 1));
      wr(0, 8'd0);
      wr(1, 8'd200);
      wr(2, ctl(0, 0, 0, 1));
      idle(20);
      wr(1, 8'd5);
      chk(count_val > 8'd100, "R8 running write no load", count_val, 190);
      wr(2, ctl(0, 0, 1, 1));
      v = count_val;
      idle(30);
      chk(count_val == v, "R7 frozen", count_val, v);
      wr(1, 8'd7);
      chk(count_val == 8'd7, "R8 stopped write loads", count_val, 7);
   endtask

   task automatic t_event();
      int i0, p0;
      wr(2, ctl(2, 0, 1, 0));
      cntr_in = 1'b0;
      idle(5);
      wr(0, 8'd0);
      wr(1, 8'd2);
      wr(2, ctl(2, 0, 0, 0));
      p0 = pin_seen;
      pin(1'b1);
      chk(count_val == 8'd1, "R5 rise counted", count_val, 1);
      chk(pin_seen == p0, "R9 no pin irq on rise edge0", pin_seen - p0, 0);
      pin(1'b0);
      chk(count_val == 8'd1, "R5 fall ignored", count_val, 1);
      chk(pin_seen == p0 + 1, "R9 pin irq on fall edge0", pin_seen - p0, 1);
      pin(1'b1);
      pin(1'b0);
      i0 = irq_seen;
      pin(1'b1);
      chk(count_val == 8'd2 && irq_seen == i0 + 1, "R5 underflow on third rise", irq_seen - i0, 1);
      wr(2, ctl(2, 1, 0, 0));
      p0 = pin_seen;
      pin(1'b0);
      chk(count_val == 8'd1, "R5 fall counted edge1", count_val, 1);
      chk(pin_seen == p0, "R9 no pin irq on fall edge1", pin_seen - p0, 0);
      pin(1'b1);
      chk(count_val == 8'd1, "R5 rise ignored edge1", count_val, 1);
      chk(pin_seen == p0 + 1, "R9 pin irq on rise edge1", pin_seen - p0, 1);
   endtask

   task automatic t_width();
      int d;
      logic [7:0] v;
      wr(2, ctl(3, 0, 1, 1));
      cntr_in = 1'b0;
      idle(5);
      wr(0, 8'd0);
      wr(1, 8'd200);
      wr(2, ctl(3, 0, 0, 1));
      idle(40);
      chk(count_val == 8'd200, "R6 hold while low edge0", count_val, 200);
      @(negedge clk);
      cntr_in = 1'b1;
      idle(40);
      cntr_in = 1'b0;
      idle(10);
      d = 200 - int'(count_val);
      chk(d >= 18 && d <= 22, "R6 count while high", d, 20);
      wr(2, ctl(3, 1, 0, 1));
      v = count_val;
      idle(20);
      chk(count_val < v, "R6 count while low edge1", count_val, v - 10);
   endtask

   task automatic t_stop_underflow();
      int i0;
      wr(2, ctl(2, 0, 1, 0));
      cntr_in = 1'b0;
      idle(5);
      wr(0, 8'd0);
      wr(1, 8'd0);
      wr(2, ctl(2, 0, 0, 0));
      idle(2);
      i0 = irq_seen;
      @(negedge clk);
      cntr_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = ctl(2, 0, 1, 0);
      @(negedge clk);
      wr_en = 1'b0;
      chk(tmr_irq == 1'b1, "R10 irq with stop write", tmr_irq, 1);
      idle(2);
      chk(irq_seen == i0 + 1, "R10 irq count", irq_seen - i0, 1);
   endtask

   initial begin
      #4_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_period(1, 2, 1);
      t_period(0, 1, 0);
      t_period(2, 0, 1);
      t_pulse();
      t_stop_load();
      t_event();
      t_width();
      t_stop_underflow();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule